// File: doc/BRIEF.md
# Lane Stripe Distributor and Collector

This block connects one valid/ready word stream to the parallel per-lane word ports of a multi-lane serial engine. On the transmit side it gathers stream words into a beat. A beat is one word for every active lane. It hands the beat to the engine only when the beat is complete. On the receive side it takes a beat of words that were captured in parallel, one per physical lane, and replays them on the output stream one at a time, in logical lane order.

A small table gives each logical lane index a physical lane number. The table resets to the identity mapping, and writes that name a physical lane the block does not implement are refused. The lane-enable mask is derived from the table. In single mode it enables only the physical lane that logical lane 0 maps to. In stripe mode it enables the lanes that the first N logical lanes map to.

A transfer starts with a pulse that carries the mode, the lane count N and the word count. The transfer runs a number of beats: the word count divided by N in stripe mode, or the word count in single mode. Every beat is sent on transmit and also received on receive. Requests that cannot be striped evenly are refused before they start.

Top module: `lane_stripe_xlate`

## Requirements
- R1: After reset, logical lane i maps to physical lane i, no transfer is active, every valid and ready output is low, `lane_mask` is 4'b0001, and both error pulses are low.
- R2: A map write whose lane number is 4 or more leaves the table unchanged and raises `map_err` for exactly the cycle after the write. A write with a lane number of 3 or less updates the entry and leaves `map_err` low.
- R3: While no transfer is active, `lane_mask` has exactly one bit set, at the position of the physical lane mapped to logical lane 0.
- R4: During a stripe transfer with N lanes, `lane_mask` is the OR of the one-hot bits of the physical lanes mapped to logical lanes 0 to N-1.
- R5: A start is refused with a one-cycle `xfer_err` pulse, and no transfer begins, when the word count is zero, or when stripe mode is selected with N equal to 0, N greater than 4, or a word count that is not a multiple of N.
- R6: In stripe mode, stream word k of a transfer goes to beat k/N and logical lane k mod N. It appears on bits [8p+7:8p] of `tx_data`, where p is the physical lane mapped to that logical lane. Physical lanes that carry no word read as zero.
- R7: A transmit beat is offered only once all of its words have been taken from the input stream. The input stream is not ready while a complete beat is waiting.
- R8: In stripe mode, each received beat is emitted as N output words. Output word k comes from bits [8p+7:8p] of `rx_data`, where p is the physical lane mapped to logical lane k, and the words come out in order k = 0 to N-1.
- R9: A new receive beat is not accepted until every word of the previous beat has left the output stream. A stalled output word stays valid and unchanged.
- R10: In single mode, the lane count input is ignored. Each beat carries one word, on the physical lane mapped to logical lane 0, and the mask enables only that lane.
- R11: `xfer_busy` rises the cycle after an accepted start. It falls once every beat has been transmitted and received and the last received word has been consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_we | input | 1 | Lane map write strobe |
| map_idx | input | 2 | Logical lane index to write |
| map_lane | input | 3 | Physical lane number for that index |
| map_err | output | 1 | One-cycle pulse: the last map write was refused |
| xfer_start | input | 1 | Start pulse, ignored while busy |
| xfer_stripe | input | 1 | 1 = stripe mode, 0 = single mode |
| xfer_lanes | input | 3 | Active lane count N for stripe mode |
| xfer_words | input | 8 | Word count of the transfer |
| xfer_err | output | 1 | One-cycle pulse: the last start was refused |
| xfer_busy | output | 1 | Transfer in progress |
| lane_mask | output | 4 | Enable mask of physical lanes |
| s_valid | input | 1 | Input stream valid |
| s_ready | output | 1 | Input stream ready |
| s_data | input | 8 | Input stream word |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Engine takes the transmit beat |
| tx_data | output | 32 | Transmit words, 8 bits per physical lane |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Block takes the receive beat |
| rx_data | input | 32 | Received words, 8 bits per physical lane |
| m_valid | output | 1 | Output stream valid |
| m_ready | input | 1 | Output stream ready |
| m_data | output | 8 | Output stream word |

## Verification
A fill counter that slips, or a wrong table entry, puts a word on the wrong physical slice of `tx_data`, or in the wrong place in the output order. The first beat of the next transfer shows it, a few cycles after the start. A collector that loses count either holds `rx_ready` low forever or accepts a beat over words that have not been drained. The first case leaves `xfer_busy` stuck high. The second breaks the order of output words within one beat. The bench sweeps every lane count under three lane permutations, with irregular ready patterns on both sides. It also tries every refused start and every refused map value.

// File: rtl/lane_stripe_pkg.sv
// Shared types and helpers for the lane stripe block.
// Assumes nothing beyond elaboration-time constant arguments.
package lane_stripe_pkg;

    typedef enum logic {
        XM_SINGLE = 1'b0,
        XM_STRIPE = 1'b1
    } xfer_mode_e;

    // Index width that stays legal for a single-entry table.
    function automatic int idx_bits(input int entries);
        return (entries < 2) ? 1 : $clog2(entries);
    endfunction

endpackage

// File: rtl/lane_map_table.sv
// Logical-to-physical lane table with the derived lane masks.
// Assumes: write lane values at or above PHYS_LANES are refused, so every
// stored entry names a lane that exists; n_act never exceeds PHYS_LANES.
module lane_map_table #(
    parameter int PHYS_LANES = 4,
    parameter int LANE_ID_W  = 3,
    parameter int IDX_W      = 2,
    parameter int NW         = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [LANE_ID_W-1:0]            wr_lane,
    input  logic [NW-1:0]                   n_act,
    output logic                            wr_err,
    output logic [PHYS_LANES*LANE_ID_W-1:0] lane_of,
    output logic [PHYS_LANES-1:0]           prim_mask,
    output logic [PHYS_LANES-1:0]           all_mask
);

    logic [LANE_ID_W-1:0] ent [PHYS_LANES];
    logic                 lane_ok;

    assign lane_ok = int'(wr_lane) < PHYS_LANES;

    // Table storage: identity after reset, legal writes only.
    always_ff @(posedge clk) begin
        for (int e = 0; e < PHYS_LANES; e++) begin
            if (!rst_n)
                ent[e] <= LANE_ID_W'(e);
            else if (wr_en && lane_ok && int'(wr_idx) == e)
                ent[e] <= wr_lane;
        end
    end

    // Refusal pulse for an out-of-range lane number.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= wr_en && !lane_ok;
    end

    // Flatten the table for the data paths.
    generate
        for (genvar g = 0; g < PHYS_LANES; g++) begin : g_flat
            assign lane_of[g*LANE_ID_W +: LANE_ID_W] = ent[g];
        end
    endgenerate

    // Masks: the lane of logical 0, and the union over the first n_act lanes.
    always_comb begin
        prim_mask = '0;
        all_mask  = '0;
        for (int p = 0; p < PHYS_LANES; p++) begin
            if (int'(ent[0]) == p) prim_mask[p] = 1'b1;
            for (int k = 0; k < PHYS_LANES; k++)
                if (k < int'(n_act) && int'(ent[k]) == p) all_mask[p] = 1'b1;
        end
    end

endmodule

// File: rtl/lane_stripe_tx.sv
// Transmit distributor: packs stream words into one beat of n_act words and
// places logical slot k on the physical lane named by lane_of.
// Assumes 1 <= n_act <= PHYS_LANES whenever arm is high.
module lane_stripe_tx #(
    parameter int WORD_W     = 8,
    parameter int PHYS_LANES = 4,
    parameter int LANE_ID_W  = 3,
    parameter int NW         = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            arm,
    input  logic [NW-1:0]                   n_act,
    input  logic [PHYS_LANES*LANE_ID_W-1:0] lane_of,
    input  logic                            s_valid,
    input  logic [WORD_W-1:0]               s_data,
    output logic                            s_ready,
    output logic                            tx_valid,
    input  logic                            tx_ready,
    output logic [PHYS_LANES*WORD_W-1:0]    tx_data,
    output logic                            beat_done
);

    logic [WORD_W-1:0] slot [PHYS_LANES];
    logic [NW-1:0]     fill;

    assign s_ready   = arm && (fill < n_act);
    assign tx_valid  = (n_act != '0) && (fill == n_act);
    assign beat_done = tx_valid && tx_ready;

    // Fill level: counts taken words, clears when the beat leaves.
    always_ff @(posedge clk) begin
        if (!rst_n)                  fill <= '0;
        else if (beat_done)          fill <= '0;
        else if (s_valid && s_ready) fill <= fill + NW'(1);
    end

    // Slot storage: the next free logical slot takes the stream word.
    always_ff @(posedge clk) begin
        if (s_valid && s_ready)
            for (int k = 0; k < PHYS_LANES; k++)
                if (int'(fill) == k) slot[k] <= s_data;
    end

    // Route logical slots onto their physical lanes; idle lanes read zero.
    always_comb begin
        tx_data = '0;
        for (int p = 0; p < PHYS_LANES; p++)
            for (int k = 0; k < PHYS_LANES; k++)
                if (k < int'(n_act) && int'(lane_of[k*LANE_ID_W +: LANE_ID_W]) == p)
                    tx_data[p*WORD_W +: WORD_W] = slot[k];
    end

endmodule

// File: rtl/lane_stripe_rx.sv
// Receive collector: captures one parallel beat, reorders it by logical
// lane and replays it word by word on the output stream.
// Assumes 1 <= n_act <= PHYS_LANES whenever arm is high.
module lane_stripe_rx #(
    parameter int WORD_W     = 8,
    parameter int PHYS_LANES = 4,
    parameter int LANE_ID_W  = 3,
    parameter int NW         = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            arm,
    input  logic [NW-1:0]                   n_act,
    input  logic [PHYS_LANES*LANE_ID_W-1:0] lane_of,
    input  logic                            rx_valid,
    input  logic [PHYS_LANES*WORD_W-1:0]    rx_data,
    output logic                            rx_ready,
    output logic                            m_valid,
    input  logic                            m_ready,
    output logic [WORD_W-1:0]               m_data,
    output logic                            beat_done,
    output logic                            holding
);

    logic [WORD_W-1:0] slot [PHYS_LANES];
    logic [NW-1:0]     have;
    logic [NW-1:0]     rd;

    assign rx_ready  = arm && (have == '0);
    assign beat_done = rx_valid && rx_ready;
    assign m_valid   = rd < have;
    assign holding   = have != '0;

    // Drain control: load the count on capture, step on each output handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have <= '0;
            rd   <= '0;
        end else if (beat_done) begin
            have <= n_act;
            rd   <= '0;
        end else if (m_valid && m_ready) begin
            if (rd + NW'(1) == have) begin
                have <= '0;
                rd   <= '0;
            end else begin
                rd <= rd + NW'(1);
            end
        end
    end

    // Capture: logical slot k takes the word of its mapped physical lane.
    always_ff @(posedge clk) begin
        if (beat_done)
            for (int k = 0; k < PHYS_LANES; k++)
                for (int p = 0; p < PHYS_LANES; p++)
                    if (int'(lane_of[k*LANE_ID_W +: LANE_ID_W]) == p)
                        slot[k] <= rx_data[p*WORD_W +: WORD_W];
    end

    // Output word selection by read pointer.
    always_comb begin
        m_data = '0;
        for (int k = 0; k < PHYS_LANES; k++)
            if (int'(rd) == k) m_data = slot[k];
    end

endmodule

// File: rtl/lane_stripe_xlate.sv
// Top: transfer control, lane table, transmit distributor and receive
// collector. A transfer moves the same number of beats in both directions.
// Assumes the map is not rewritten while a transfer is active.
module lane_stripe_xlate
    import lane_stripe_pkg::*;
#(
    parameter int WORD_W     = 8,
    parameter int PHYS_LANES = 4,
    parameter int LANE_ID_W  = 3,
    parameter int CNT_W      = 8,
    localparam int IDX_W     = idx_bits(PHYS_LANES),
    localparam int NW        = $clog2(PHYS_LANES + 1),
    localparam int BUS_W     = PHYS_LANES * WORD_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  map_we,
    input  logic [IDX_W-1:0]      map_idx,
    input  logic [LANE_ID_W-1:0]  map_lane,
    output logic                  map_err,
    input  logic                  xfer_start,
    input  logic                  xfer_stripe,
    input  logic [NW-1:0]         xfer_lanes,
    input  logic [CNT_W-1:0]      xfer_words,
    output logic                  xfer_err,
    output logic                  xfer_busy,
    output logic [PHYS_LANES-1:0] lane_mask,
    input  logic                  s_valid,
    output logic                  s_ready,
    input  logic [WORD_W-1:0]     s_data,
    output logic                  tx_valid,
    input  logic                  tx_ready,
    output logic [BUS_W-1:0]      tx_data,
    input  logic                  rx_valid,
    output logic                  rx_ready,
    input  logic [BUS_W-1:0]      rx_data,
    output logic                  m_valid,
    input  logic                  m_ready,
    output logic [WORD_W-1:0]     m_data
);

    xfer_mode_e                      mode_q;
    logic [NW-1:0]                   n_q;
    logic [CNT_W-1:0]                tx_left, rx_left;
    logic [PHYS_LANES*LANE_ID_W-1:0] lane_of;
    logic [PHYS_LANES-1:0]           prim_mask, all_mask;
    logic                            tx_beat, rx_beat, rx_hold;
    logic [NW-1:0]                   divisor;
    logic                            refuse;
    logic [CNT_W-1:0]                beats;

    assign divisor = (xfer_lanes == '0) ? NW'(1) : xfer_lanes;

    // Start screening and beat count of the requested transfer.
    always_comb begin
        refuse = (xfer_words == '0);
        if (xfer_stripe)
            refuse = refuse || (xfer_lanes == '0) || (int'(xfer_lanes) > PHYS_LANES)
                     || ((xfer_words % CNT_W'(divisor)) != '0);
        beats = xfer_stripe ? xfer_words / CNT_W'(divisor) : xfer_words;
    end

    assign xfer_busy = (tx_left != '0) || (rx_left != '0) || rx_hold;
    assign lane_mask = (xfer_busy && mode_q == XM_STRIPE) ? all_mask : prim_mask;

    // Transfer control: latch mode and lane count, count beats down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= XM_SINGLE;
            n_q      <= NW'(1);
            tx_left  <= '0;
            rx_left  <= '0;
            xfer_err <= 1'b0;
        end else begin
            xfer_err <= 1'b0;
            if (xfer_start && !xfer_busy) begin
                if (refuse) begin
                    xfer_err <= 1'b1;
                end else begin
                    mode_q  <= xfer_stripe ? XM_STRIPE : XM_SINGLE;
                    n_q     <= xfer_stripe ? xfer_lanes : NW'(1);
                    tx_left <= beats;
                    rx_left <= beats;
                end
            end else begin
                if (tx_beat) tx_left <= tx_left - CNT_W'(1);
                if (rx_beat) rx_left <= rx_left - CNT_W'(1);
            end
        end
    end

    lane_map_table #(
        .PHYS_LANES(PHYS_LANES), .LANE_ID_W(LANE_ID_W), .IDX_W(IDX_W), .NW(NW)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .wr_en(map_we), .wr_idx(map_idx),
        .wr_lane(map_lane), .n_act(n_q), .wr_err(map_err), .lane_of(lane_of),
        .prim_mask(prim_mask), .all_mask(all_mask)
    );

    lane_stripe_tx #(
        .WORD_W(WORD_W), .PHYS_LANES(PHYS_LANES), .LANE_ID_W(LANE_ID_W), .NW(NW)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .arm(tx_left != '0), .n_act(n_q),
        .lane_of(lane_of), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .beat_done(tx_beat)
    );

    lane_stripe_rx #(
        .WORD_W(WORD_W), .PHYS_LANES(PHYS_LANES), .LANE_ID_W(LANE_ID_W), .NW(NW)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .arm(rx_left != '0), .n_act(n_q),
        .lane_of(lane_of), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .m_valid(m_valid), .m_ready(m_ready),
        .m_data(m_data), .beat_done(rx_beat), .holding(rx_hold)
    );

endmodule

// File: rtl/lane_stripe_chk.sv
// Protocol checker for lane_stripe_xlate, attached by bind below.
// Assumes the map stays unchanged while a beat is being offered.
module lane_stripe_chk #(
    parameter int WORD_W     = 8,
    parameter int PHYS_LANES = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         s_ready,
    input logic                         tx_valid,
    input logic                         tx_ready,
    input logic [PHYS_LANES*WORD_W-1:0] tx_data,
    input logic                         rx_ready,
    input logic                         m_valid,
    input logic                         m_ready,
    input logic [WORD_W-1:0]            m_data,
    input logic                         xfer_err,
    input logic                         xfer_busy,
    input logic [PHYS_LANES-1:0]        lane_mask
);

    // R7
    full_beat_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !s_ready);

    // R6
    tx_beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R9
    drain_before_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !rx_ready);

    // R9
    out_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data));

    // R5
    refused_not_started_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |-> !xfer_busy);

    // R3
    idle_mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |-> $countones(lane_mask) == 1);

endmodule

bind lane_stripe_xlate lane_stripe_chk #(
    .WORD_W(WORD_W), .PHYS_LANES(PHYS_LANES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_ready(rx_ready),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .xfer_err(xfer_err), .xfer_busy(xfer_busy), .lane_mask(lane_mask)
);

// File: tb/lane_stripe_xlate_tb.sv
`timescale 1ns/1ps
module lane_stripe_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_we = 1'b0;
    logic [1:0]  map_idx = '0;
    logic [2:0]  map_lane = '0;
    logic        map_err;
    logic        xfer_start = 1'b0;
    logic        xfer_stripe = 1'b0;
    logic [2:0]  xfer_lanes = '0;
    logic [7:0]  xfer_words = '0;
    logic        xfer_err, xfer_busy;
    logic [3:0]  lane_mask;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [7:0]  s_data = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [31:0] rx_data = '0;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic [7:0]  m_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int run_id = 0;
    int m_cnt = 0;
    int map_sw [4];

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    lane_stripe_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_idx(map_idx),
        .map_lane(map_lane), .map_err(map_err), .xfer_start(xfer_start),
        .xfer_stripe(xfer_stripe), .xfer_lanes(xfer_lanes),
        .xfer_words(xfer_words), .xfer_err(xfer_err), .xfer_busy(xfer_busy),
        .lane_mask(lane_mask), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_data(rx_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] word_of(input int i);
        return 8'(i * 37 + 11);
    endfunction

    function automatic logic [7:0] rx_of(input int b, input int p);
        return 8'(b * 29 + p * 71 + 5);
    endfunction

    function automatic logic [3:0] prim_exp();
        return 4'(1 << map_sw[0]);
    endfunction

    task automatic write_map(input int idx, input int lane, input bit exp_err);
        @(negedge clk);
        map_we = 1'b1; map_idx = 2'(idx); map_lane = 3'(lane);
        @(negedge clk);
        map_we = 1'b0;
        if (!exp_err) map_sw[idx] = lane;
        chk(map_err == exp_err, "R2 map_err", 32'(map_err), 32'(exp_err));
        chk(lane_mask == prim_exp(), "R3 idle mask after map write", 32'(lane_mask),
            32'(prim_exp()));
    endtask

    task automatic try_bad(input bit stripe, input int n, input int words);
        @(negedge clk);
        xfer_start = 1'b1; xfer_stripe = stripe; xfer_lanes = 3'(n); xfer_words = 8'(words);
        @(negedge clk);
        xfer_start = 1'b0;
        chk(xfer_err == 1'b1, "R5 refused start err", 32'(xfer_err), 1);
        chk(xfer_busy == 1'b0, "R5 refused start busy", 32'(xfer_busy), 0);
        @(negedge clk);
        chk(!s_ready && !rx_ready, "R5 no traffic after refusal",
            32'({s_ready, rx_ready}), 0);
    endtask

    task automatic run_xfer(input bit stripe, input int n, input int words);
        int nw, beats, wbase, rbase, seed;
        logic [3:0] exp_mask;
        nw    = stripe ? n : 1;
        beats = words / nw;
        run_id++;
        wbase = run_id * 64;
        rbase = run_id * 16;
        seed  = run_id;
        m_cnt = 0;
        exp_mask = '0;
        for (int k = 0; k < nw; k++) exp_mask[map_sw[k]] = 1'b1;
        @(negedge clk);
        xfer_start = 1'b1; xfer_stripe = stripe; xfer_lanes = 3'(n); xfer_words = 8'(words);
        @(negedge clk);
        xfer_start = 1'b0;
        chk(xfer_err == 1'b0, "R5 legal start not refused", 32'(xfer_err), 0);
        chk(xfer_busy == 1'b1, "R11 busy after start", 32'(xfer_busy), 1);
        if (stripe) chk(lane_mask == exp_mask, "R4 stripe mask", 32'(lane_mask), 32'(exp_mask));
        else        chk(lane_mask == prim_exp(), "R10 single mask", 32'(lane_mask), 32'(prim_exp()));
        fork
            begin : feeder
                int i = 0;
                while (i < words) begin
                    @(negedge clk);
                    s_valid = 1'b1; s_data = word_of(wbase + i);
                    #1;
                    if (s_ready) i++;
                end
                @(negedge clk);
                s_valid = 1'b0;
            end
            begin : tx_sink
                int b = 0;
                logic [31:0] exp;
                while (b < beats) begin
                    @(negedge clk);
                    tx_ready = ((cyc * 3 + seed) % 4) != 0;
                    #1;
                    if (tx_valid && tx_ready) begin
                        exp = '0;
                        for (int k = 0; k < nw; k++)
                            exp[map_sw[k]*8 +: 8] = word_of(wbase + b * nw + k);
                        if (stripe) chk(tx_data == exp, "R6 tx beat", tx_data, exp);
                        else        chk(tx_data == exp, "R10 tx beat", tx_data, exp);
                        chk(!s_ready, "R7 input stalled on full beat", 32'(s_ready), 0);
                        b++;
                    end
                end
                @(negedge clk);
                tx_ready = 1'b0;
            end
            begin : rx_src
                int b = 0;
                while (b < beats) begin
                    @(negedge clk);
                    rx_valid = 1'b1;
                    for (int p = 0; p < 4; p++) rx_data[p*8 +: 8] = rx_of(rbase + b, p);
                    #1;
                    if (rx_ready) begin
                        chk(m_cnt >= b * nw, "R9 capture after drain", 32'(m_cnt), 32'(b * nw));
                        b++;
                    end
                end
                @(negedge clk);
                rx_valid = 1'b0;
            end
            begin : m_sink
                logic       held = 1'b0;
                logic [7:0] held_d = '0;
                logic [7:0] exp;
                while (m_cnt < words) begin
                    @(negedge clk);
                    if (held)
                        chk(m_valid && m_data == held_d, "R9 stalled word held",
                            32'(m_data), 32'(held_d));
                    m_ready = ((cyc * 5 + seed) % 3) != 0;
                    #1;
                    held = m_valid && !m_ready;
                    held_d = m_data;
                    if (m_valid && m_ready) begin
                        exp = rx_of(rbase + m_cnt / nw, map_sw[m_cnt % nw]);
                        if (stripe) chk(m_data == exp, "R8 output order", 32'(m_data), 32'(exp));
                        else        chk(m_data == exp, "R10 output word", 32'(m_data), 32'(exp));
                        m_cnt++;
                    end
                end
                @(negedge clk);
                m_ready = 1'b0;
            end
        join
        for (int w = 0; w < 4 && xfer_busy; w++) @(negedge clk);
        chk(xfer_busy == 1'b0, "R11 busy falls at end", 32'(xfer_busy), 0);
        chk(lane_mask == prim_exp(), "R3 mask back to primary", 32'(lane_mask), 32'(prim_exp()));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int cfg [3][4];
        cfg = '{'{0, 1, 2, 3}, '{2, 0, 3, 1}, '{3, 1, 0, 2}};
        for (int i = 0; i < 4; i++) map_sw[i] = i;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!xfer_busy, "R1 busy", 32'(xfer_busy), 0);
        chk(!s_ready && !tx_valid, "R1 tx side idle", 32'({s_ready, tx_valid}), 0);
        chk(!rx_ready && !m_valid, "R1 rx side idle", 32'({rx_ready, m_valid}), 0);
        chk(lane_mask == 4'b0001, "R1 identity mask", 32'(lane_mask), 1);
        chk(!map_err && !xfer_err, "R1 error pulses", 32'({map_err, xfer_err}), 0);
        // R1 identity map seen through a full-width stripe transfer
        run_xfer(1'b1, 4, 8);
        // R2 refusal sweep over every index and every illegal lane
        for (int idx = 0; idx < 4; idx++)
            for (int ln = 4; ln < 8; ln++)
                write_map(idx, ln, 1'b1);
        // R5 refused starts
        try_bad(1'b1, 0, 4);
        try_bad(1'b1, 5, 5);
        try_bad(1'b1, 3, 4);
        try_bad(1'b1, 2, 0);
        try_bad(1'b0, 1, 0);
        // main sweep over maps, lane counts and modes
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < 4; i++) write_map(i, cfg[c][i], 1'b0);
            for (int n = 1; n <= 4; n++) run_xfer(1'b1, n, n * 3);
            run_xfer(1'b0, 3, 5);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule